// File: doc/BRIEF.md
# IDE PIO Register Access Sequencer

This block moves bytes and 16-bit words between a host and the task-file registers of an ATA/IDE drive that is attached through a parallel-port style pin set. It drives the three register address lines, the active-low chip select, the read and write strobes and the output enable of the data port. Each access follows a fixed order: the address and chip select are set up before a strobe, the strobe is held for a set number of cycles, and for writes the data port is turned around on either side of the strobe. During reads the chip select stays active for one cycle after the read strobe is released. Without that extra cycle the drive can lose the first word of a transfer.

The host asks for work with a one-cycle request. The request carries an operation code, a register address, a width flag, write data and a data-phase flag. The block answers with a one-cycle acknowledge that carries the read data and an error flag. The command operation runs a whole exchange. It reads the status register until the drive reports ready, writes the command byte, and, if a data phase is requested, waits for the data-request bit and then reads a full 256-word sector. Only the first 64 words (128 bytes) are passed to the host. The remaining words are still read from the drive and then dropped.

Top module: `ide_pio_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, chip select, read strobe and write strobe are high (inactive), the data-port output enable is low and `ack` is low.
- R2: A register read (op 0) drives the address with chip select low for one cycle before the read strobe falls. The read strobe stays low for exactly STROBE_CYC cycles. When the read strobe rises, chip select is still low, and it goes high one cycle later. `ack` rises STROBE_CYC+4 clock edges after the edge that samples `req`.
- R3: A register write (op 1) turns on the output enable with the data one cycle before chip select falls. The write strobe stays low for exactly STROBE_CYC cycles. Chip select and the write strobe rise together while the address and output enable are held for one more cycle, and then the output enable goes low. `ack` rises STROBE_CYC+5 edges after the edge that samples `req`.
- R4: With `word`=1 all 16 data bits are moved. With `word`=0 a write drives bits 15:8 as zero, and a read uses the same word cycle but returns only bits 7:0, with bits 15:8 of `rdata` zero.
- R5: The read and write strobes are never low at the same time, and neither is low while chip select is high.
- R6: A command (op 2) reads register 7 repeatedly until a status with bit 7 (busy) clear and bit 6 (ready) set is returned. Only after that read does it write the low byte of `wdata` to register 7.
- R7: If ready is not seen within TIMEOUT_CYC cycles of polling, the command ends with `ack` and `err`=1 and no write cycle is issued.
- R8: For a command with `xfer`=1, register 7 is read until bit 3 (data request) is set with bit 7 clear. Then exactly SECTOR_WORDS word reads of register 0 follow, and the first KEEP_WORDS of them are presented on `sec_data` with `sec_valid`, in read order.
- R9: If the data-request bit is not seen within TIMEOUT_CYC cycles after the command write, the command ends with `err`=1 and no register 0 read takes place.
- R10: `ack` is high for exactly one cycle per request, and `err` is 0 on every operation that completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request, accepted when idle |
| op | input | 2 | 0 register read, 1 register write, 2 command |
| addr | input | 3 | Task-file register address for register operations |
| word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| wdata | input | 16 | Write data; low byte is the command code for op 2 |
| xfer | input | 1 | Command has a sector read phase |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with ack |
| err | output | 1 | Timeout flag, valid with ack |
| sec_valid | output | 1 | Kept sector word is valid |
| sec_data | output | 16 | Kept sector word |
| ide_addr | output | 3 | Drive register address lines |
| ide_cs_n | output | 1 | Chip select, active low |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_dout | output | 16 | Data driven toward the drive |
| ide_oe | output | 1 | Data port output enable |
| ide_din | input | 16 | Data from the drive |

## Verification
Register reads acknowledge STROBE_CYC+4 edges after the sampling edge and register writes STROBE_CYC+5 edges after it. The bench raises `req` just after a falling edge and counts falling edges until `ack` is seen, so it expects STROBE_CYC+5 and STROBE_CYC+6 counts. A monitor samples the drive pins on every falling edge. It measures strobe widths, what chip select and output enable do in the sample before a strobe falls and in the sample where it rises, and in which order the output enable drops. Command outcomes have a variable number of polls, so for those the bench waits for `ack` and then checks the counts the stub recorded: status reads before the command write, register 0 reads, and kept words in order.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  typedef enum logic [1:0] {
    HOP_RD  = 2'd0,
    HOP_WR  = 2'd1,
    HOP_CMD = 2'd2
  } host_op_e;

  typedef enum logic [2:0] {
    P_IDLE, P_OE, P_SETUP, P_STROBE, P_REL, P_DONE
  } bus_phase_e;

  typedef enum logic [2:0] {
    C_IDLE, C_REG, C_POLL, C_ISSUE, C_DRQ, C_DATA
  } ctrl_state_e;

  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd7;
  localparam int ST_BUSY  = 7;
  localparam int ST_READY = 6;
  localparam int ST_DREQ  = 3;
endpackage

// File: rtl/ide_bus_phy.sv
module ide_bus_phy
  import ide_pio_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_we,
  input  logic [2:0]  start_addr,
  input  logic [15:0] start_data,
  output logic        done,
  output logic [15:0] rd_data,
  output logic [2:0]  ide_addr,
  output logic        ide_cs_n,
  output logic        ide_rd_n,
  output logic        ide_wr_n,
  output logic [15:0] ide_dout,
  output logic        ide_oe,
  input  logic [15:0] ide_din
);
  localparam int CW = $clog2(STROBE_CYC + 1);
  localparam logic [CW-1:0] CLAST = CW'(STROBE_CYC - 1);

  bus_phase_e  ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        we_q;
  logic [2:0]  addr_q;
  logic [15:0] data_q, rdat_q;
  logic        load_en, cap_en;

  assign load_en = (ph_q == P_IDLE) && start;
  assign cap_en  = (ph_q == P_STROBE) && (cnt_q == CLAST) && !we_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      P_IDLE:   if (start) ph_d = start_we ? P_OE : P_SETUP;
      P_OE:     ph_d = P_SETUP;
      P_SETUP:  begin ph_d = P_STROBE; cnt_d = '0; end
      P_STROBE: if (cnt_q == CLAST) ph_d = P_REL;
                else cnt_d = cnt_q + 1'b1;
      P_REL:    ph_d = P_DONE;
      default:  ph_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= P_IDLE;
      cnt_q  <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdat_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (load_en) begin
        we_q   <= start_we;
        addr_q <= start_addr;
        data_q <= start_data;
      end
      if (cap_en) rdat_q <= ide_din;
    end
  end

  assign done     = (ph_q == P_DONE);
  assign rd_data  = rdat_q;
  assign ide_addr = addr_q;
  assign ide_dout = data_q;
  assign ide_cs_n = !((ph_q == P_SETUP) || (ph_q == P_STROBE) ||
                      ((ph_q == P_REL) && !we_q));
  assign ide_rd_n = !((ph_q == P_STROBE) && !we_q);
  assign ide_wr_n = !((ph_q == P_STROBE) && we_q);
  assign ide_oe   = we_q && ((ph_q == P_OE) || (ph_q == P_SETUP) ||
                             (ph_q == P_STROBE) || (ph_q == P_REL));

  // Checker: cycles the current strobe has been low, counted independently
  logic [CW-1:0] chk_low;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_low <= '0;
    else if (!ide_rd_n || !ide_wr_n) chk_low <= chk_low + 1'b1;
    else chk_low <= '0;
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n));
  assert_strobe_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_rd_n || !ide_wr_n) |-> !ide_cs_n);
  assert_rd_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_rd_n) |-> $past(!ide_cs_n));
  assert_rd_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ide_rd_n) |-> !ide_cs_n);
  assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ide_rd_n) || $rose(ide_wr_n)) |-> (chk_low == CW'(STROBE_CYC)));
  assert_wr_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_wr_n |-> ide_oe);
  assert_wr_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ide_wr_n) |-> (ide_cs_n && ide_oe && $stable(ide_addr)));
endmodule

// File: rtl/ide_wait_timer.sv
module ide_wait_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TLIM = TW'(LIMIT);

  logic [TW-1:0] cnt_q;
  logic          inc_en;

  assign expired = (cnt_q == TLIM);
  assign inc_en  = run && !expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc_en) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ide_cmd_ctrl.sv
module ide_cmd_ctrl
  import ide_pio_pkg::*;
#(
  parameter int SECTOR_WORDS = 256,
  parameter int KEEP_WORDS   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  op,
  input  logic [2:0]  addr,
  input  logic        word,
  input  logic [15:0] wdata,
  input  logic        xfer,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        err,
  output logic        sec_valid,
  output logic [15:0] sec_data,
  output logic        phy_start,
  output logic        phy_we,
  output logic [2:0]  phy_addr,
  output logic [15:0] phy_data,
  input  logic        phy_done,
  input  logic [15:0] phy_rdata,
  output logic        tmr_clr,
  output logic        tmr_run,
  input  logic        tmr_expired
);
  localparam int IW = $clog2(SECTOR_WORDS);
  localparam logic [IW-1:0] ILAST = IW'(SECTOR_WORDS - 1);
  localparam logic [IW:0]   IKEEP = (IW+1)'(KEEP_WORDS);

  ctrl_state_e st_q, st_d;
  logic        word_q, word_d, xfer_q, xfer_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [IW-1:0] idx_q, idx_d;
  logic        ack_d, err_q, err_d, secv_d;
  logic [15:0] rdata_q, rdata_d, secd_q, secd_d;
  logic        go_d, we_d;
  logic [2:0]  pa_d;
  logic [15:0] pd_d;
  logic        stat_ok, dreq_ok;

  assign stat_ok = !phy_rdata[ST_BUSY] && phy_rdata[ST_READY];
  assign dreq_ok = !phy_rdata[ST_BUSY] && phy_rdata[ST_DREQ];
  assign tmr_run = (st_q == C_POLL) || (st_q == C_DRQ);

  always_comb begin
    st_d = st_q; word_d = word_q; xfer_d = xfer_q; cmd_d = cmd_q;
    idx_d = idx_q; err_d = err_q; rdata_d = rdata_q; secd_d = secd_q;
    ack_d = 1'b0; secv_d = 1'b0; tmr_clr = 1'b0;
    go_d = 1'b0; we_d = phy_we; pa_d = phy_addr; pd_d = phy_data;
    case (st_q)
      C_IDLE: if (req) begin
        word_d = word; xfer_d = xfer; cmd_d = wdata[7:0]; err_d = 1'b0;
        go_d = 1'b1;
        if (op == HOP_CMD) begin
          we_d = 1'b0; pa_d = REG_STAT; tmr_clr = 1'b1; st_d = C_POLL;
        end else begin
          we_d = (op == HOP_WR); pa_d = addr;
          pd_d = word ? wdata : {8'h00, wdata[7:0]};
          st_d = C_REG;
        end
      end
      C_REG: if (phy_done) begin
        rdata_d = word_q ? phy_rdata : {8'h00, phy_rdata[7:0]};
        ack_d = 1'b1; st_d = C_IDLE;
      end
      C_POLL: if (phy_done) begin
        if (stat_ok) begin
          go_d = 1'b1; we_d = 1'b1; pa_d = REG_STAT; pd_d = {8'h00, cmd_q};
          st_d = C_ISSUE;
        end else if (tmr_expired) begin
          err_d = 1'b1; ack_d = 1'b1; st_d = C_IDLE;
        end else begin
          go_d = 1'b1; we_d = 1'b0; pa_d = REG_STAT;
        end
      end
      C_ISSUE: if (phy_done) begin
        if (xfer_q) begin
          go_d = 1'b1; we_d = 1'b0; pa_d = REG_STAT; tmr_clr = 1'b1;
          st_d = C_DRQ;
        end else begin
          ack_d = 1'b1; st_d = C_IDLE;
        end
      end
      C_DRQ: if (phy_done) begin
        if (dreq_ok) begin
          go_d = 1'b1; we_d = 1'b0; pa_d = REG_DATA; idx_d = '0;
          st_d = C_DATA;
        end else if (tmr_expired) begin
          err_d = 1'b1; ack_d = 1'b1; st_d = C_IDLE;
        end else begin
          go_d = 1'b1; we_d = 1'b0; pa_d = REG_STAT;
        end
      end
      C_DATA: if (phy_done) begin
        if ({1'b0, idx_q} < IKEEP) begin
          secv_d = 1'b1; secd_d = phy_rdata;
        end
        if (idx_q == ILAST) begin
          ack_d = 1'b1; st_d = C_IDLE;
        end else begin
          idx_d = idx_q + 1'b1; go_d = 1'b1; we_d = 1'b0; pa_d = REG_DATA;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= C_IDLE; word_q <= 1'b0; xfer_q <= 1'b0; cmd_q <= '0;
      idx_q <= '0; ack <= 1'b0; err_q <= 1'b0; rdata_q <= '0;
      sec_valid <= 1'b0; secd_q <= '0;
      phy_start <= 1'b0; phy_we <= 1'b0; phy_addr <= '0; phy_data <= '0;
    end else begin
      st_q <= st_d; word_q <= word_d; xfer_q <= xfer_d; cmd_q <= cmd_d;
      idx_q <= idx_d; ack <= ack_d; err_q <= err_d; rdata_q <= rdata_d;
      sec_valid <= secv_d; secd_q <= secd_d;
      phy_start <= go_d; phy_we <= we_d; phy_addr <= pa_d; phy_data <= pd_d;
    end
  end

  assign rdata    = rdata_q;
  assign err      = err_q;
  assign sec_data = secd_q;

  // Checker: kept words delivered since the last accepted request
  logic [IW:0] kept_chk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kept_chk <= '0;
    else if (req && st_q == C_IDLE) kept_chk <= '0;
    else if (sec_valid) kept_chk <= kept_chk + 1'b1;
  end

  assert_keep_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |-> (kept_chk < IKEEP));
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq #(
  parameter int STROBE_CYC   = 2,
  parameter int TIMEOUT_CYC  = 200,
  parameter int SECTOR_WORDS = 256,
  parameter int KEEP_WORDS   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  op,
  input  logic [2:0]  addr,
  input  logic        word,
  input  logic [15:0] wdata,
  input  logic        xfer,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        err,
  output logic        sec_valid,
  output logic [15:0] sec_data,
  output logic [2:0]  ide_addr,
  output logic        ide_cs_n,
  output logic        ide_rd_n,
  output logic        ide_wr_n,
  output logic [15:0] ide_dout,
  output logic        ide_oe,
  input  logic [15:0] ide_din
);
  logic        phy_start, phy_we, phy_done;
  logic [2:0]  phy_addr;
  logic [15:0] phy_data, phy_rdata;
  logic        tmr_clr, tmr_run, tmr_expired;

  ide_cmd_ctrl #(
    .SECTOR_WORDS(SECTOR_WORDS),
    .KEEP_WORDS  (KEEP_WORDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .word(word),
    .wdata(wdata), .xfer(xfer), .ack(ack), .rdata(rdata), .err(err),
    .sec_valid(sec_valid), .sec_data(sec_data),
    .phy_start(phy_start), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_data(phy_data), .phy_done(phy_done), .phy_rdata(phy_rdata),
    .tmr_clr(tmr_clr), .tmr_run(tmr_run), .tmr_expired(tmr_expired)
  );

  ide_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .expired(tmr_expired)
  );

  ide_bus_phy #(.STROBE_CYC(STROBE_CYC)) u_phy (
    .clk(clk), .rst_n(rst_n), .start(phy_start), .start_we(phy_we),
    .start_addr(phy_addr), .start_data(phy_data), .done(phy_done),
    .rd_data(phy_rdata), .ide_addr(ide_addr), .ide_cs_n(ide_cs_n),
    .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n), .ide_dout(ide_dout),
    .ide_oe(ide_oe), .ide_din(ide_din)
  );
endmodule

// File: tb/ide_pio_seq_bench.sv
module ide_pio_seq_bench;
  localparam int S = 2;
  localparam int TMO = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] op = 2'd0;
  logic [2:0] addr = 3'd0;
  logic word = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic xfer = 1'b0;
  logic ack, err, sec_valid, ide_cs_n, ide_rd_n, ide_wr_n, ide_oe;
  logic [15:0] rdata, sec_data, ide_dout, ide_din;
  logic [2:0] ide_addr;

  always #2 clk = ~clk;

  ide_pio_seq #(.STROBE_CYC(S), .TIMEOUT_CYC(TMO), .SECTOR_WORDS(256),
                .KEEP_WORDS(64)) u_ide_pio_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .word(word),
    .wdata(wdata), .xfer(xfer), .ack(ack), .rdata(rdata), .err(err),
    .sec_valid(sec_valid), .sec_data(sec_data), .ide_addr(ide_addr),
    .ide_cs_n(ide_cs_n), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_dout(ide_dout), .ide_oe(ide_oe), .ide_din(ide_din)
  );

  // ---------------- drive stub ----------------
  logic [15:0] regs [8];
  int busy_reads, drq_delay, stat_reads, post_reads, data_idx;
  int wr_cnt, stat_at_write, sec_cnt, sec_bad;
  logic [15:0] post_stat, last_wdata;
  logic [2:0]  last_waddr;
  bit cmd_written;
  int v_setup, v_width, v_rdrel, v_wrrel, v_oe, v_excl;
  int rdlow, wrlow;
  logic prev_cs, prev_rd, prev_wr, prev_oe;
  logic [15:0] stub_val;

  always_comb begin
    if (ide_addr == 3'd7) begin
      if (!cmd_written) stub_val = (stat_reads < busy_reads) ? 16'h0080 : 16'h0050;
      else stub_val = (post_reads < drq_delay) ? 16'h0050 : post_stat;
    end else if (ide_addr == 3'd0) stub_val = 16'hA500 + data_idx[15:0];
    else stub_val = regs[ide_addr];
  end
  assign ide_din = (!ide_cs_n && !ide_rd_n) ? stub_val : 16'hDEAD;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_rd = 1'b1; prev_wr = 1'b1; prev_oe = 1'b0;
      rdlow = 0; wrlow = 0;
    end else begin
      if (prev_rd && !ide_rd_n && prev_cs) v_setup++;
      if (prev_wr && !ide_wr_n && (prev_cs || !prev_oe)) v_setup++;
      if (prev_cs && !ide_cs_n && ide_wr_n && !ide_rd_n) v_setup++;
      if ((!ide_rd_n && !ide_wr_n) || ((!ide_rd_n || !ide_wr_n) && ide_cs_n)) v_excl++;
      if (prev_oe && !ide_oe && !prev_cs) v_oe++;
      if (!prev_rd && ide_rd_n) begin
        if (rdlow != S) v_width++;
        if (ide_cs_n) v_rdrel++;
        if (ide_addr == 3'd7) begin
          if (cmd_written) post_reads++; else stat_reads++;
        end
        if (ide_addr == 3'd0) data_idx++;
        rdlow = 0;
      end
      if (!prev_wr && ide_wr_n) begin
        if (wrlow != S) v_width++;
        if (!ide_cs_n || !ide_oe) v_wrrel++;
        wr_cnt++; last_waddr = ide_addr; last_wdata = ide_dout;
        stat_at_write = stat_reads;
        if (ide_addr == 3'd7) cmd_written = 1'b1;
        else regs[ide_addr] = ide_dout;
        wrlow = 0;
      end
      if (!ide_rd_n) rdlow++;
      if (!ide_wr_n) wrlow++;
      if (sec_valid) begin
        if (sec_data != 16'hA500 + sec_cnt[15:0]) sec_bad++;
        sec_cnt++;
      end
      prev_cs = ide_cs_n; prev_rd = ide_rd_n; prev_wr = ide_wr_n; prev_oe = ide_oe;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic stub_clear(input int busy, input int dly, input logic [15:0] pstat);
    busy_reads = busy; drq_delay = dly; post_stat = pstat;
    stat_reads = 0; post_reads = 0; data_idx = 0; cmd_written = 1'b0;
    wr_cnt = 0; stat_at_write = -1; sec_cnt = 0; sec_bad = 0;
    v_setup = 0; v_width = 0; v_rdrel = 0; v_wrrel = 0; v_oe = 0; v_excl = 0;
  endtask

  int n_edges;
  logic [15:0] got_rdata;
  logic got_err;

  task automatic host_req(input logic [1:0] o, input logic [2:0] a, input logic w,
                          input logic [15:0] d, input logic x, input string tag);
    op = o; addr = a; word = w; wdata = d; xfer = x; req = 1'b1;
    n_edges = 0;
    do begin
      @(negedge clk);
      n_edges++;
      if (n_edges == 1) req = 1'b0;
    end while (!ack && n_edges < 20000);
    got_rdata = rdata; got_err = err;
    @(negedge clk);
    chk(!ack, {tag, " R10 ack one cycle"}, ack, 0);
  endtask

  task automatic check_protocol(input string tag);
    chk(v_setup == 0, {tag, " setup order R2 R3"}, v_setup, 0);
    chk(v_width == 0, {tag, " strobe width R2 R3"}, v_width, 0);
    chk(v_rdrel == 0, {tag, " cs held after read R2"}, v_rdrel, 0);
    chk(v_wrrel == 0, {tag, " write release R3"}, v_wrrel, 0);
    chk(v_oe == 0, {tag, " oe after cs release R3"}, v_oe, 0);
    chk(v_excl == 0, {tag, " strobe exclusivity R5"}, v_excl, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ide_cs_n && ide_rd_n && ide_wr_n, "R1 strobes idle in reset",
        {ide_cs_n, ide_rd_n, ide_wr_n}, 7);
    chk(!ide_oe && !ack, "R1 oe/ack low in reset", {ide_oe, ack}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ide_cs_n && ide_rd_n && ide_wr_n && !ide_oe && !ack, "R1 idle after reset",
        {ide_cs_n, ide_rd_n, ide_wr_n, ide_oe, ack}, 5'b11100);
  endtask

  task automatic t_reg_read();
    stub_clear(0, 0, 16'h0058);
    regs[5] = 16'h3C7A;
    host_req(2'd0, 3'd5, 1'b1, 16'h0, 1'b0, "word read");
    chk(got_rdata == 16'h3C7A, "R4 word read data", got_rdata, 16'h3C7A);
    chk(n_edges == S + 5, "R2 read ack latency", n_edges, S + 5);
    chk(!got_err, "R10 read err clear", got_err, 0);
    host_req(2'd0, 3'd5, 1'b0, 16'h0, 1'b0, "byte read");
    chk(got_rdata == 16'h007A, "R4 byte read low byte", got_rdata, 16'h007A);
    check_protocol("read");
  endtask

  task automatic t_reg_write();
    stub_clear(0, 0, 16'h0058);
    host_req(2'd1, 3'd2, 1'b0, 16'h1201, 1'b0, "byte write");
    chk(n_edges == S + 6, "R3 write ack latency", n_edges, S + 6);
    chk(regs[2] == 16'h0001, "R4 byte write upper zero", regs[2], 16'h0001);
    host_req(2'd1, 3'd4, 1'b1, 16'hBEEF, 1'b0, "word write");
    chk(regs[4] == 16'hBEEF, "R4 word write value", regs[4], 16'hBEEF);
    host_req(2'd0, 3'd4, 1'b1, 16'h0, 1'b0, "readback");
    chk(got_rdata == 16'hBEEF, "R4 word readback", got_rdata, 16'hBEEF);
    chk(wr_cnt == 2, "R3 write count", wr_cnt, 2);
    check_protocol("write");
  endtask

  task automatic t_cmd_nodata();
    stub_clear(3, 0, 16'h0058);
    host_req(2'd2, 3'd0, 1'b0, 16'h00E2, 1'b0, "spin-down");
    chk(!got_err, "R10 command err clear", got_err, 0);
    chk(wr_cnt == 1 && last_waddr == 3'd7, "R6 command written to reg 7",
        {wr_cnt[3:0], 1'b0, last_waddr}, 8'h17);
    chk(last_wdata == 16'h00E2, "R6 command code", last_wdata, 16'h00E2);
    chk(stat_at_write == 4, "R6 write only after ready status", stat_at_write, 4);
    chk(data_idx == 0, "R6 no data reads", data_idx, 0);
    check_protocol("cmd");
  endtask

  task automatic t_cmd_identify();
    stub_clear(2, 3, 16'h0058);
    host_req(2'd2, 3'd0, 1'b0, 16'h00EC, 1'b1, "identify");
    chk(!got_err, "R8 identify err clear", got_err, 0);
    chk(last_wdata == 16'h00EC, "R6 identify code", last_wdata, 16'h00EC);
    chk(post_reads == 4, "R8 DRQ polled until set", post_reads, 4);
    chk(data_idx == 256, "R8 full sector read", data_idx, 256);
    chk(sec_cnt == 64, "R8 kept word count", sec_cnt, 64);
    chk(sec_bad == 0, "R8 kept words in order", sec_bad, 0);
    check_protocol("identify");
  endtask

  task automatic t_ready_timeout();
    stub_clear(100000, 0, 16'h0058);
    host_req(2'd2, 3'd0, 1'b0, 16'h00E2, 1'b0, "ready timeout");
    chk(got_err, "R7 timeout error flag", got_err, 1);
    chk(wr_cnt == 0, "R7 no command write", wr_cnt, 0);
    chk(stat_reads > 1, "R7 status polled", stat_reads, 2);
  endtask

  task automatic t_drq_timeout();
    stub_clear(0, 0, 16'h0050);
    host_req(2'd2, 3'd0, 1'b0, 16'h00EC, 1'b1, "drq timeout");
    chk(got_err, "R9 DRQ timeout error", got_err, 1);
    chk(data_idx == 0, "R9 no data reads", data_idx, 0);
    chk(sec_cnt == 0, "R9 nothing delivered", sec_cnt, 0);
    host_req(2'd0, 3'd5, 1'b1, 16'h0, 1'b0, "after timeout");
    chk(!got_err, "R10 err clears on next op", got_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'h0;
    stub_clear(0, 0, 16'h0058);
    t_reset();
    t_reg_read();
    t_reg_write();
    t_cmd_nodata();
    t_cmd_identify();
    t_ready_timeout();
    t_drq_timeout();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule